// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Detection

This block receives asynchronous serial frames on a single input line. An external tick arrives 16 times per bit period. The block recovers each bit from three samples taken around the middle of the bit period and assembles a frame from these bits: a start bit, 8 or 9 word bits sent least significant bit first, and one or two stop bits. When a frame has been accepted, the word is placed in a one-entry holding register. A flag and an optional interrupt tell the consumer that a word is waiting.

While each frame arrives, the block checks it for four faults. The first is noise: samples within a bit that disagree. The second is a parity mismatch, checked when parity is on. The third is a low stop bit. The fourth is a word that arrives before the previous one has been read. The error flags are sticky. A consumer clears them by pulsing the status-read strobe and then, in a later cycle, the data-read strobe. Configuration is taken at each start bit.

Top module: `uart_ovs_rx`

## Requirements
- R1: Each bit is decided by majority over the samples at tick indices 6, 7 and 8 (0-based, of 16 ticks per bit; index 0 is the first tick on which the synchronised line is seen low in idle). The line value at the other 13 ticks of a bit has no influence on the decision.
- R2: If the three samples of any bit (start, word, parity or stop) are not all equal, `err_noise` is set when the frame is accepted.
- R3: If the start bit votes 1, the receiver returns to idle. It stores nothing and sets no flag.
- R4: With `word9`=0, 8 bits are received and `rx_data[8]` reads 0. With `word9`=1, 9 bits are received. The first bit after the start bit lands in `rx_data[0]`. With parity on, the parity bit is the top received bit and stays in `rx_data`.
- R5: With `par_en`=1, `err_parity` is set when the top received bit differs from the XOR of the bits below it (`par_odd`=0) or from its inverse (`par_odd`=1). With `par_en`=0, `err_parity` is never set.
- R6: `stop2` selects one (0) or two (1) stop bits. `err_frame` is set if any stop bit votes 0.
- R7: An accepted frame sets `buf_full`, and `data_rd` clears it. `irq_full` is high exactly while `buf_full` and `full_irq_en` are both high.
- R8: If a frame completes while `buf_full` is high and no read occurs in that cycle, `rx_data` keeps the old word and `err_overrun` is set. The noise, parity and frame status of the dropped frame is discarded.
- R9: A `data_rd` in the same cycle as a frame completion frees the buffer first. The new word is stored, `buf_full` stays high, and no overrun is flagged.
- R10: Error flags stay set until a `data_rd` that follows a `stat_rd` given in an earlier cycle. A `data_rd` without a preceding `stat_rd` leaves them set.
- R11: With `rx_enable` low, any frame in progress is abandoned. No word is stored and no flag changes.
- R12: `irq_parity` is high exactly while `err_parity` and `par_irq_en` are both high.
- R13: After reset, `buf_full`, all error flags, both interrupts and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| rx_enable | input | 1 | Receiver enable |
| par_en | input | 1 | Parity check enable |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| word9 | input | 1 | 1 = 9-bit word, 0 = 8-bit word (parity included) |
| stop2 | input | 1 | 1 = two stop bits, 0 = one |
| stat_rd | input | 1 | Status-read strobe (arms error clearing) |
| data_rd | input | 1 | Data-read strobe |
| full_irq_en | input | 1 | Enable for buffer-full interrupt |
| par_irq_en | input | 1 | Enable for parity interrupt |
| rx_data | output | 9 | Held received word |
| buf_full | output | 1 | Unread word present |
| err_noise | output | 1 | Sticky noise flag |
| err_parity | output | 1 | Sticky parity flag |
| err_frame | output | 1 | Sticky stop-bit flag |
| err_overrun | output | 1 | Sticky overrun flag |
| irq_full | output | 1 | Buffer-full interrupt |
| irq_parity | output | 1 | Parity interrupt |

## Verification
A frame completion and a consumer read can land in the same clock cycle. The block then has to choose between storing the new word and flagging an overrun. The bench provokes this by raising `data_rd` for the single cycle after the tick that samples the middle of the last stop bit, while an older word is still unread. The result is judged correct when the new word is held, `buf_full` stays high and `err_overrun` stays low. A separate test sends a frame against a full buffer with no read, and expects the old word to be kept and an overrun to be flagged.

// File: rtl/uart_ovs_pkg.sv
package uart_ovs_pkg;

    localparam int WORD_W = 9;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rx_st_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              noise;
        logic              perr;
        logic              ferr;
    } frame_t;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[1] & s[2]) | (s[0] & s[2]);
    endfunction

    function automatic logic disagree3(input logic [2:0] s);
        return (|s) & ~(&s);
    endfunction

    // top received bit is the parity bit; compare with the fold of the bits below it
    function automatic logic parity_bad(input logic [WORD_W-1:0] w,
                                        input logic w9, input logic odd);
        logic [WORD_W-2:0] d;
        logic              p;
        if (w9) begin
            d = w[WORD_W-2:0];
            p = w[WORD_W-1];
        end else begin
            d = {1'b0, w[WORD_W-3:0]};
            p = w[WORD_W-2];
        end
        return p != ((^d) ^ odd);
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk) begin
        if (rst) ff <= '1;
        else     ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_ovs_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   rxs,
    input  logic   enable,
    input  logic   par_en,
    input  logic   par_odd,
    input  logic   word9,
    input  logic   stop2,
    output logic   frm_valid,
    output frame_t frm_q
);
    localparam int              CW    = $clog2(OVS);
    localparam logic [CW-1:0]   S_MID = CW'(OVS/2 - 1);
    localparam logic [CW-1:0]   S_LO  = CW'(OVS/2 - 2);
    localparam logic [CW-1:0]   S_HI  = CW'(OVS/2);
    localparam logic [CW-1:0]   S_END = CW'(OVS - 1);

    rx_st_e            st;
    logic [CW-1:0]     cnt;
    logic [3:0]        bidx;
    logic [1:0]        smp;
    logic [WORD_W-1:0] sh;
    logic              noise_acc, ferr_acc;
    logic              c_w9, c_pe, c_po, c_s2;

    logic              v, nz;
    logic [3:0]        nbits, last_idx;
    logic [WORD_W-1:0] word_al;

    always_comb begin
        v        = vote3({rxs, smp});
        nz       = disagree3({rxs, smp});
        nbits    = c_w9 ? 4'd9 : 4'd8;
        last_idx = nbits + (c_s2 ? 4'd2 : 4'd1);
        word_al  = c_w9 ? sh : {1'b0, sh[WORD_W-2:0]};
    end

    always_ff @(posedge clk) begin
        frm_valid <= 1'b0;
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            bidx      <= '0;
            smp       <= '0;
            sh        <= '0;
            noise_acc <= 1'b0;
            ferr_acc  <= 1'b0;
            c_w9      <= 1'b0;
            c_pe      <= 1'b0;
            c_po      <= 1'b0;
            c_s2      <= 1'b0;
            frm_q     <= '0;
        end else if (!enable) begin
            st <= ST_IDLE;
        end else if (tick) begin
            case (st)
                ST_IDLE: begin
                    if (!rxs) begin
                        st        <= ST_RUN;
                        cnt       <= CW'(1);
                        bidx      <= '0;
                        noise_acc <= 1'b0;
                        ferr_acc  <= 1'b0;
                        c_w9      <= word9;
                        c_pe      <= par_en;
                        c_po      <= par_odd;
                        c_s2      <= stop2;
                    end
                end
                ST_RUN: begin
                    cnt <= (cnt == S_END) ? '0 : cnt + CW'(1);
                    if (cnt == S_LO)  smp[0] <= rxs;
                    if (cnt == S_MID) smp[1] <= rxs;
                    if (cnt == S_HI) begin
                        bidx      <= bidx + 4'd1;
                        noise_acc <= noise_acc | nz;
                        if (bidx == 4'd0) begin
                            if (v) st <= ST_IDLE;
                        end else if (bidx <= nbits) begin
                            for (int i = 0; i < WORD_W; i++)
                                if (bidx == 4'(i + 1)) sh[i] <= v;
                        end else begin
                            ferr_acc <= ferr_acc | ~v;
                            if (bidx == last_idx) begin
                                st          <= ST_IDLE;
                                frm_valid   <= 1'b1;
                                frm_q.data  <= word_al;
                                frm_q.noise <= noise_acc | nz;
                                frm_q.ferr  <= ferr_acc | ~v;
                                frm_q.perr  <= c_pe & parity_bad(word_al, c_w9, c_po);
                            end
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_ovs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_valid,
    input  frame_t            frm,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              full_irq_en,
    input  logic              par_irq_en,
    output logic [WORD_W-1:0] rx_data,
    output logic              buf_full,
    output logic              err_noise,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_overrun,
    output logic              irq_full,
    output logic              irq_parity
);
    logic armed, clr, store, drop;

    always_comb begin
        clr   = data_rd & armed;
        store = frm_valid & (~buf_full | data_rd);
        drop  = frm_valid & buf_full & ~data_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed       <= 1'b0;
            rx_data     <= '0;
            buf_full    <= 1'b0;
            err_noise   <= 1'b0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            if (stat_rd)      armed <= 1'b1;
            else if (data_rd) armed <= 1'b0;

            if (store) begin
                rx_data  <= frm.data;
                buf_full <= 1'b1;
            end else if (data_rd) begin
                buf_full <= 1'b0;
            end

            err_noise   <= (err_noise   & ~clr) | (store & frm.noise);
            err_parity  <= (err_parity  & ~clr) | (store & frm.perr);
            err_frame   <= (err_frame   & ~clr) | (store & frm.ferr);
            err_overrun <= (err_overrun & ~clr) | drop;
        end
    end

    assign irq_full   = buf_full & full_irq_en;
    assign irq_parity = err_parity & par_irq_en;
endmodule

// File: rtl/uart_ovs_rx.sv
module uart_ovs_rx
    import uart_ovs_pkg::*;
#(
    parameter int OVS_RATE    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       smp_tick,
    input  logic       rx_in,
    input  logic       rx_enable,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       word9,
    input  logic       stop2,
    input  logic       stat_rd,
    input  logic       data_rd,
    input  logic       full_irq_en,
    input  logic       par_irq_en,
    output logic [8:0] rx_data,
    output logic       buf_full,
    output logic       err_noise,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_overrun,
    output logic       irq_full,
    output logic       irq_parity
);
    logic   rxs;
    logic   frm_valid;
    frame_t frm_q;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rx_in),
        .q   (rxs)
    );

    uart_rx_framer #(.OVS(OVS_RATE)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .tick      (smp_tick),
        .rxs       (rxs),
        .enable    (rx_enable),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .word9     (word9),
        .stop2     (stop2),
        .frm_valid (frm_valid),
        .frm_q     (frm_q)
    );

    uart_rx_status u_status (
        .clk         (clk),
        .rst         (rst),
        .frm_valid   (frm_valid),
        .frm         (frm_q),
        .stat_rd     (stat_rd),
        .data_rd     (data_rd),
        .full_irq_en (full_irq_en),
        .par_irq_en  (par_irq_en),
        .rx_data     (rx_data),
        .buf_full    (buf_full),
        .err_noise   (err_noise),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .err_overrun (err_overrun),
        .irq_full    (irq_full),
        .irq_parity  (irq_parity)
    );
endmodule

// File: rtl/uart_ovs_rx_chk.sv
module uart_ovs_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_enable,
    input logic       data_rd,
    input logic       frm_valid,
    input logic [8:0] rx_data,
    input logic       buf_full,
    input logic       err_noise,
    input logic       err_frame,
    input logic       err_overrun
);
    // R8
    overrun_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && buf_full && !data_rd) |=> ($stable(rx_data) && err_overrun));

    // R9
    same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && buf_full && data_rd) |=> (buf_full && !$rose(err_overrun)));

    // R7
    read_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !frm_valid) |=> !buf_full);

    // R7
    fill_chk: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> buf_full);

    // R11
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> !frm_valid);

    // R10
    sticky_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (!data_rd && err_frame) |=> err_frame);

    // R10
    sticky_noise_chk: assert property (@(posedge clk) disable iff (rst)
        (!data_rd && err_noise) |=> err_noise);
endmodule

bind uart_ovs_rx uart_ovs_rx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_enable   (rx_enable),
    .data_rd     (data_rd),
    .frm_valid   (frm_valid),
    .rx_data     (rx_data),
    .buf_full    (buf_full),
    .err_noise   (err_noise),
    .err_frame   (err_frame),
    .err_overrun (err_overrun)
);

// File: tb/tb_uart_ovs_rx.sv
`timescale 1ns/1ps
module tb_uart_ovs_rx;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_tick = 1'b0, rx_in = 1'b1, rx_enable = 1'b0;
    logic par_en = 1'b0, par_odd = 1'b0, word9 = 1'b0, stop2 = 1'b0;
    logic stat_rd = 1'b0, data_rd = 1'b0, full_irq_en = 1'b0, par_irq_en = 1'b0;
    logic [8:0] rx_data;
    logic buf_full, err_noise, err_parity, err_frame, err_overrun, irq_full, irq_parity;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    uart_ovs_rx dut (
        .clk(clk), .rst(rst), .smp_tick(smp_tick), .rx_in(rx_in), .rx_enable(rx_enable),
        .par_en(par_en), .par_odd(par_odd), .word9(word9), .stop2(stop2),
        .stat_rd(stat_rd), .data_rd(data_rd), .full_irq_en(full_irq_en), .par_irq_en(par_irq_en),
        .rx_data(rx_data), .buf_full(buf_full), .err_noise(err_noise), .err_parity(err_parity),
        .err_frame(err_frame), .err_overrun(err_overrun), .irq_full(irq_full), .irq_parity(irq_parity)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic v, input bit rd);
        @(negedge clk) rx_in = v;
        repeat (2) @(negedge clk);
        smp_tick = 1'b1;
        @(negedge clk);
        smp_tick = 1'b0;
        data_rd = rd;
        @(negedge clk) data_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b1, 1'b0);
    endtask

    // noise_at / ferr_at: frame bit index (0 = start), -1 for none
    task automatic send_frame(input logic [8:0] w, input int noise_at, input int ferr_at,
                              input bit garbage, input bit rd_done);
        int nb, total;
        nb    = word9 ? 9 : 8;
        total = 1 + nb + (stop2 ? 2 : 1);
        for (int b = 0; b < total; b++) begin
            logic bv;
            if (b == 0)        bv = 1'b0;
            else if (b <= nb)  bv = w[b-1];
            else               bv = (b == ferr_at) ? 1'b0 : 1'b1;
            for (int s = 0; s < 16; s++) begin
                logic sv;
                sv = bv;
                if (garbage && b >= 1 && b <= nb && (s < 6 || s > 8)) sv = ~bv;
                if (b == noise_at && s == 7) sv = ~sv;
                tick(sv, rd_done && (b == total - 1) && (s == 8));
            end
        end
        idle(12);
    endtask

    function automatic logic [8:0] mk_word(input logic [8:0] d, input bit w9, input bit pe,
                                           input bit po, input bit bad);
        logic [8:0] w;
        int nb;
        nb = w9 ? 9 : 8;
        w = w9 ? d : {1'b0, d[7:0]};
        if (pe) w[nb-1] = (^(w & 9'((1 << (nb - 1)) - 1))) ^ po ^ bad;
        return w;
    endfunction

    task automatic read_clear();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
        data_rd = 1'b1;
        @(negedge clk) data_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_flags(input string req, input bit n, input bit p, input bit f, input bit o);
        chk({req, " noise"},   err_noise,   n);
        chk({req, " parity"},  err_parity,  p);
        chk({req, " frame"},   err_frame,   f);
        chk({req, " overrun"}, err_overrun, o);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0C1A));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk("R13 data", rx_data, 9'h0);
        chk("R13 full", buf_full, 1'b0);
        chk_flags("R13", 0, 0, 0, 0);
        chk("R13 irqs", {irq_full, irq_parity}, 2'b00);

        rx_enable = 1'b1;
        full_irq_en = 1'b1;
        idle(4);

        // R4 8-bit, LSB first, one stop
        send_frame(9'h0A5, -1, -1, 0, 0);
        chk("R4 8-bit data", rx_data, 9'h0A5);
        chk("R7 full set", buf_full, 1'b1);
        chk("R7 irq_full", irq_full, 1'b1);
        chk_flags("R4 clean", 0, 0, 0, 0);
        full_irq_en = 1'b0;
        @(negedge clk);
        chk("R7 irq_full masked", irq_full, 1'b0);
        read_clear();
        chk("R7 full cleared", buf_full, 1'b0);

        // R1 samples outside the window inverted
        word9 = 1'b1;
        send_frame(9'h13C, -1, -1, 1, 0);
        chk("R1 window vote", rx_data, 9'h13C);
        chk("R1 no noise", err_noise, 1'b0);
        read_clear();

        // R2 noise on the start bit
        word9 = 1'b0;
        send_frame(9'h033, 0, -1, 0, 0);
        chk("R2 start noise data", rx_data, 9'h033);
        chk("R2 start noise", err_noise, 1'b1);
        read_clear();
        chk("R10 cleared after status+data", err_noise, 1'b0);

        // R3 false starts: short glitch, then disagreeing window voting 1
        for (int s = 0; s < 16; s++) tick(s > 2, 1'b0);
        idle(8);
        for (int s = 0; s < 16; s++) tick(!(s < 6 || s == 6), 1'b0);
        idle(8);
        chk("R3 nothing stored", buf_full, 1'b0);
        chk_flags("R3", 0, 0, 0, 0);

        // R6 two stop bits, second low; R10 data read alone keeps flags
        stop2 = 1'b1;
        send_frame(9'h0F0, -1, 10, 0, 0);
        chk("R6 data", rx_data, 9'h0F0);
        chk("R6 frame error", err_frame, 1'b1);
        @(negedge clk) data_rd = 1'b1;
        @(negedge clk) data_rd = 1'b0;
        @(negedge clk);
        chk("R10 flag kept", err_frame, 1'b1);
        chk("R7 plain read empties", buf_full, 1'b0);
        read_clear();
        chk("R10 flag cleared", err_frame, 1'b0);
        stop2 = 1'b0;

        // R5 + R12 odd parity error with interrupt
        par_en = 1'b1; par_odd = 1'b1; word9 = 1'b1; par_irq_en = 1'b1;
        send_frame(mk_word(9'h05A, 1, 1, 1, 1), -1, -1, 0, 0);
        chk("R5 parity error", err_parity, 1'b1);
        chk("R12 irq_parity", irq_parity, 1'b1);
        par_irq_en = 1'b0;
        @(negedge clk);
        chk("R12 irq masked", irq_parity, 1'b0);
        read_clear();
        chk("R12 irq low after clear", irq_parity, 1'b0);
        par_en = 1'b0; par_odd = 1'b0; word9 = 1'b0;

        // R8 overrun keeps the old word, drops the noisy new one
        send_frame(9'h011, -1, -1, 0, 0);
        send_frame(9'h0EE, 3, -1, 0, 0);
        chk("R8 old data kept", rx_data, 9'h011);
        chk_flags("R8", 0, 0, 0, 1);
        read_clear();
        chk("R8 overrun cleared", err_overrun, 1'b0);

        // R9 read in the completion cycle
        send_frame(9'h022, -1, -1, 0, 0);
        send_frame(9'h0C4, -1, -1, 0, 1);
        chk("R9 new data", rx_data, 9'h0C4);
        chk("R9 full", buf_full, 1'b1);
        chk("R9 no overrun", err_overrun, 1'b0);
        read_clear();

        // R11 disable mid-frame
        for (int s = 0; s < 64; s++) tick(1'b0, 1'b0);
        rx_enable = 1'b0;
        for (int s = 0; s < 96; s++) tick(s[4], 1'b0);
        idle(4);
        rx_enable = 1'b1;
        idle(4);
        chk("R11 nothing stored", buf_full, 1'b0);
        chk_flags("R11", 0, 0, 0, 0);
        send_frame(9'h069, -1, -1, 0, 0);
        chk("R11 recovers", rx_data, 9'h069);
        read_clear();

        // random frames
        for (int k = 0; k < 40; k++) begin
            logic [8:0] d, w;
            int nb, total, nz_at, fe_at;
            bit pe, po, bad, gb;
            word9 = 1'($urandom_range(0, 1));
            stop2 = 1'($urandom_range(0, 1));
            pe = 1'($urandom_range(0, 1));
            po = 1'($urandom_range(0, 1));
            par_en = pe; par_odd = po;
            full_irq_en = 1'($urandom_range(0, 1));
            par_irq_en  = 1'($urandom_range(0, 1));
            nb = word9 ? 9 : 8;
            total = 1 + nb + (stop2 ? 2 : 1);
            d = 9'($urandom);
            bad = pe && ($urandom_range(0, 3) == 0);
            gb = 1'($urandom_range(0, 1));
            nz_at = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, total - 1)) : -1;
            fe_at = ($urandom_range(0, 3) == 0) ? int'($urandom_range(nb + 1, total - 1)) : -1;
            w = mk_word(d, word9, pe, po, bad);
            send_frame(w, nz_at, fe_at, gb, 0);
            chk("R4 random data", rx_data, w);
            chk("R7 random full", buf_full, 1'b1);
            chk_flags("R2/R5/R6 random", nz_at >= 0, bad, fe_at >= 0, 0);
            chk("R7 random irq", irq_full, full_irq_en);
            chk("R12 random irq", irq_parity, bad & par_irq_en);
            read_clear();
            chk("R10 random clear", {buf_full, err_noise, err_parity, err_frame}, 4'h0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule